// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block builds the single-error-correcting Hamming check bits for one 512-byte NAND sector while the data streams past it one byte at a time. The sector is handled as two 256-byte halves. Each half keeps its own 16-bit line parity and 6-bit column parity. An internal byte counter picks the half that a byte updates. Bytes count only while parity calculation is switched on. This lets the host move the 16 spare-area bytes through the same data path with calculation switched off, and those bytes leave the parity untouched.

Once the sector and its spare bytes have been moved, the host pulses a read strobe six times. Each strobe collects one packed check byte. Software compares these bytes with the check bits stored in the spare area. Finding the bad bit and correcting it are software tasks, so the block only produces parity. A clear pulse zeroes the parity, the byte counter and the readout position before each sector.

Top module: `nand_ecc_gen`

## Requirements
- R1: A byte is accepted only in a cycle where `byte_vld` and `calc_en` are both 1. A strobe with `calc_en` at 0 changes neither parity nor the byte counter.
- R2: A clear pulse (`ecc_clr` at 1 on a clock edge) zeroes `lpr`, `cpr`, the byte counter, the readout position and `rd_byte` at that edge.
- R3: For an accepted byte with index i in its half and XOR-reduced parity p, for each k in 0..7, line bit 2k+1 of that half toggles by p when bit k of i is 1, and line bit 2k toggles by p when bit k of i is 0.
- R4: For each set data bit at position b and each j in 0..2, column bit 2j+1 of that half toggles when bit j of b is 1, and column bit 2j toggles when bit j of b is 0.
- R5: Accepted bytes 0..255 of the sector update `lpr[15:0]` and `cpr[5:0]`. Bytes 256..511 update `lpr[31:16]` and `cpr[11:6]`. After 512 accepted bytes the count starts again at the low half.
- R6: Each read strobe loads `rd_byte` on that clock edge with the next slot, in this order: `lpr[7:0]`, `lpr[15:8]`, `{cpr[5:0],2'b11}`, `lpr[23:16]`, `lpr[31:24]`, `{cpr[11:6],2'b11}`.
- R7: The readout position returns to the first slot after the sixth read.
- R8: When a clear pulse and an accepted byte strobe fall on the same edge, the clear wins and the byte is discarded.
- R9: `rst` is synchronous and active high. It sets the same zero state as a clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_clr | input | 1 | Clear pulse for parity, byte counter and readout position |
| calc_en | input | 1 | Parity calculation enable for strobed bytes |
| byte_vld | input | 1 | Byte transfer strobe |
| byte_data | input | 8 | Transferred byte |
| rd_stb | input | 1 | Readout strobe, one packed byte per pulse |
| rd_byte | output | 8 | Registered packed check byte |
| lpr | output | 32 | Line parity, low half in bits 15:0 |
| cpr | output | 12 | Column parity, low half in bits 5:0 |

## Verification
The assertions assume that `rst` is held for at least one edge before the first transfer. They also assume that every strobe lasts exactly one cycle per byte, so one strobed cycle always means one byte. The line-pair check expects exactly zero or eight line bits to toggle per accepted byte. This holds only because one byte changes only one half. The bench therefore drives one byte per strobe cycle and never overlaps a read with a clear. It produces clears, plain-mode bytes and same-edge clear-plus-byte only as single isolated cycles, so each assertion sees a clean antecedent.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int BYTE_W  = 8;
  localparam int BITS_LG = 3;
  localparam int COL_W   = 2 * BITS_LG;
  localparam int SLOTS_PER_HALF = 3;

  // Mask of byte bit positions whose position bit j is set
  function automatic logic [BYTE_W-1:0] col_mask(input int j);
    logic [BYTE_W-1:0] m;
    for (int b = 0; b < BYTE_W; b++) begin
      m[b] = ((b >> j) & 1) == 1;
    end
    return m;
  endfunction
endpackage

// File: rtl/nand_ecc_fold.sv
module nand_ecc_fold
  import nand_ecc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic [BYTE_W-1:0]  data,
  output logic [2*IDX_W-1:0] lp_flip,
  output logic [COL_W-1:0]   cp_flip
);
  logic par;
  assign par = ^data;

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign lp_flip[2*k+1] = par &  idx[k];
    assign lp_flip[2*k]   = par & ~idx[k];
  end

  for (genvar j = 0; j < BITS_LG; j++) begin : g_col
    localparam logic [BYTE_W-1:0] MSK = col_mask(j);
    assign cp_flip[2*j+1] = ^(data &  MSK);
    assign cp_flip[2*j]   = ^(data & ~MSK);
  end
endmodule

// File: rtl/nand_ecc_half.sv
module nand_ecc_half
  import nand_ecc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               upd,
  input  logic [IDX_W-1:0]   idx,
  input  logic [BYTE_W-1:0]  data,
  output logic [2*IDX_W-1:0] lp,
  output logic [COL_W-1:0]   cp
);
  logic [2*IDX_W-1:0] lp_flip;
  logic [COL_W-1:0]   cp_flip;

  nand_ecc_fold #(.IDX_W(IDX_W)) u_fold (
    .idx     (idx),
    .data    (data),
    .lp_flip (lp_flip),
    .cp_flip (cp_flip)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lp <= '0;
      cp <= '0;
    end else if (upd) begin
      lp <= lp ^ lp_flip;
      cp <= cp ^ cp_flip;
    end
  end
endmodule

// File: rtl/nand_ecc_readout.sv
module nand_ecc_readout
  import nand_ecc_pkg::*;
#(
  parameter int HALVES = 2,
  parameter int LP_W   = 16,
  localparam int SLOTS = SLOTS_PER_HALF * HALVES,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    rd_stb,
  input  logic [HALVES*LP_W-1:0]  lp_all,
  input  logic [HALVES*COL_W-1:0] cp_all,
  output logic [BYTE_W-1:0]       rd_byte,
  output logic [PTR_W-1:0]        rd_ptr
);
  logic [BYTE_W-1:0] slot [SLOTS];

  for (genvar h = 0; h < HALVES; h++) begin : g_pack
    logic [2*BYTE_W-1:0] lp16;
    assign lp16 = (2*BYTE_W)'(lp_all[h*LP_W +: LP_W]);
    assign slot[3*h]   = lp16[BYTE_W-1:0];
    assign slot[3*h+1] = lp16[2*BYTE_W-1:BYTE_W];
    assign slot[3*h+2] = {cp_all[h*COL_W +: COL_W], 2'b11};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_ptr  <= '0;
      rd_byte <= '0;
    end else if (rd_stb) begin
      rd_byte <= slot[rd_ptr];
      rd_ptr  <= (rd_ptr == PTR_W'(SLOTS-1)) ? '0 : rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int HALF_BYTES = 256,
  parameter int HALVES     = 2,
  localparam int IDX_W = $clog2(HALF_BYTES),
  localparam int LP_W  = 2 * IDX_W,
  localparam int SEC_N = HALF_BYTES * HALVES,
  localparam int SEC_W = $clog2(SEC_N),
  localparam int LPR_W = HALVES * LP_W,
  localparam int CPR_W = HALVES * COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ecc_clr,
  input  logic              calc_en,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              rd_stb,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [LPR_W-1:0]  lpr,
  output logic [CPR_W-1:0]  cpr
);
  localparam int PTR_W = $clog2(SLOTS_PER_HALF * HALVES);

  logic             accept;
  logic [SEC_W-1:0] sec_cnt;
  logic [PTR_W-1:0] rd_ptr;

  // Clear outranks a same-edge byte strobe
  assign accept = byte_vld && calc_en && !ecc_clr;

  always_ff @(posedge clk) begin
    if (rst || ecc_clr) begin
      sec_cnt <= '0;
    end else if (accept) begin
      sec_cnt <= (sec_cnt == SEC_W'(SEC_N-1)) ? '0 : sec_cnt + 1'b1;
    end
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic upd;
    assign upd = accept && (sec_cnt[SEC_W-1:IDX_W] == (SEC_W-IDX_W)'(h));
    nand_ecc_half #(.IDX_W(IDX_W)) u_half (
      .clk  (clk),
      .rst  (rst),
      .clr  (ecc_clr),
      .upd  (upd),
      .idx  (sec_cnt[IDX_W-1:0]),
      .data (byte_data),
      .lp   (lpr[h*LP_W +: LP_W]),
      .cp   (cpr[h*COL_W +: COL_W])
    );
  end

  nand_ecc_readout #(.HALVES(HALVES), .LP_W(LP_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .clr     (ecc_clr),
    .rd_stb  (rd_stb),
    .lp_all  (lpr),
    .cp_all  (cpr),
    .rd_byte (rd_byte),
    .rd_ptr  (rd_ptr)
  );
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk
  import nand_ecc_pkg::*;
#(
  parameter int HALF_BYTES = 256,
  parameter int HALVES     = 2,
  localparam int IDX_W = $clog2(HALF_BYTES),
  localparam int LP_W  = 2 * IDX_W,
  localparam int SEC_W = $clog2(HALF_BYTES * HALVES),
  localparam int LPR_W = HALVES * LP_W,
  localparam int CPR_W = HALVES * COL_W,
  localparam int SLOTS = SLOTS_PER_HALF * HALVES,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst,
  input logic              ecc_clr,
  input logic              calc_en,
  input logic              byte_vld,
  input logic              rd_stb,
  input logic [BYTE_W-1:0] rd_byte,
  input logic [LPR_W-1:0]  lpr,
  input logic [CPR_W-1:0]  cpr,
  input logic [SEC_W-1:0]  sec_cnt,
  input logic [PTR_W-1:0]  rd_ptr
);
  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (lpr == '0 && cpr == '0 && rd_byte == '0 && rd_ptr == '0)); // R9

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    ecc_clr |=> (lpr == '0 && cpr == '0 && sec_cnt == '0 && rd_ptr == '0)); // R2

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (ecc_clr && byte_vld && calc_en) |=> (lpr == '0 && sec_cnt == '0)); // R8

  AST_PLAIN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!ecc_clr && byte_vld && !calc_en) |=>
      ($stable(lpr) && $stable(cpr) && $stable(sec_cnt))); // R1

  AST_LINE_PAIRS: assert property (@(posedge clk) disable iff (rst)
    (!ecc_clr && byte_vld && calc_en) |=>
      ($countones(lpr ^ $past(lpr)) == 0 || $countones(lpr ^ $past(lpr)) == IDX_W)); // R3

  AST_LOW_HALF_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!ecc_clr && byte_vld && calc_en && sec_cnt < SEC_W'(HALF_BYTES)) |=>
      ($stable(lpr[LPR_W-1:LP_W]) && $stable(cpr[CPR_W-1:COL_W]))); // R5

  AST_PAD_ONES: assert property (@(posedge clk) disable iff (rst)
    (!ecc_clr && rd_stb && (rd_ptr % 3) == 2) |=> (rd_byte[1:0] == 2'b11)); // R6

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!ecc_clr && rd_stb && rd_ptr == PTR_W'(SLOTS-1)) |=> (rd_ptr == '0)); // R7

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_ptr < PTR_W'(SLOTS)); // R7
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.HALF_BYTES(HALF_BYTES), .HALVES(HALVES)) u_chk (.*);

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ecc_clr = 1'b0;
  logic       calc_en = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_byte;
  logic [31:0] lpr;
  logic [11:0] cpr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] e_lpr;
  logic [11:0] e_cpr;
  int bcnt;
  int eptr;

  always #2 clk = ~clk;

  nand_ecc_gen u_dut (
    .clk(clk), .rst(rst), .ecc_clr(ecc_clr), .calc_en(calc_en),
    .byte_vld(byte_vld), .byte_data(byte_data), .rd_stb(rd_stb),
    .rd_byte(rd_byte), .lpr(lpr), .cpr(cpr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_zero;
    e_lpr = '0; e_cpr = '0; bcnt = 0; eptr = 0;
  endtask

  task automatic model_byte(input logic [7:0] d);
    int h, idx;
    h = bcnt / 256;
    idx = bcnt % 256;
    for (int k = 0; k < 8; k++)
      if (^d) e_lpr[h*16 + 2*k + ((idx >> k) & 1)] ^= 1'b1;
    for (int b = 0; b < 8; b++)
      if (d[b])
        for (int j = 0; j < 3; j++)
          e_cpr[h*6 + 2*j + ((b >> j) & 1)] ^= 1'b1;
    bcnt = (bcnt + 1) % 512;
  endtask

  function automatic logic [7:0] slot_exp(input int s);
    int h;
    h = s / 3;
    case (s % 3)
      0: return e_lpr[h*16 +: 8];
      1: return e_lpr[h*16 + 8 +: 8];
      default: return {e_cpr[h*6 +: 6], 2'b11};
    endcase
  endfunction

  task automatic put(input logic [7:0] d, input logic en);
    byte_vld = 1'b1; calc_en = en; byte_data = d;
    tick;
    byte_vld = 1'b0; calc_en = 1'b0;
    if (en) model_byte(d);
  endtask

  task automatic clear;
    ecc_clr = 1'b1;
    tick;
    ecc_clr = 1'b0;
    model_zero;
  endtask

  task automatic rd_one(input string req);
    rd_stb = 1'b1;
    tick;
    rd_stb = 1'b0;
    chk(req, {24'h0, rd_byte}, {24'h0, slot_exp(eptr)});
    eptr = (eptr + 1) % 6;
  endtask

  task automatic chk_par(input string req);
    chk(req, lpr, e_lpr);
    chk(req, {20'h0, cpr}, {20'h0, e_cpr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    model_zero;
    @(negedge clk);
    tick; tick;
    rst = 1'b0;
    // R9: reset state
    chk("R9 reset", {lpr[31:0]}, 32'h0);
    chk("R9 reset", {20'h0, cpr}, 32'h0);
    chk("R9 reset", {24'h0, rd_byte}, 32'h0);

    // R3 R4 R5 R6 R7 R1: full sectors under several patterns
    for (int p = 0; p < 4; p++) begin
      clear;
      for (int i = 0; i < 512; i++) begin
        logic [7:0] d;
        case (p)
          0: d = 8'(i);
          1: d = 8'(i * 37 + 5);
          2: d = 8'hFF;
          default: d = 8'((i * i) >> 3) ^ 8'(i);
        endcase
        if (p == 1 && (i % 7) == 3) put(8'(i * 11 + 1), 1'b0); // R1 plain bytes
        put(d, 1'b1);
      end
      for (int s = 0; s < 16; s++) put(8'(s * 29 + 3), 1'b0); // R1 spare bytes
      chk_par("R3 R4 R5 sector");
      for (int r = 0; r < 7; r++) rd_one("R6 R7 readout");
    end

    // R5: counter wraps to low half after 512 bytes
    clear;
    for (int i = 0; i < 512; i++) put(8'h00, 1'b1);
    put(8'h80, 1'b1);
    chk("R5 wrap", lpr, 32'h0000_5555);
    chk("R5 wrap", {20'h0, cpr}, {20'h0, e_cpr});

    // R8: clear beats same-edge byte strobe
    byte_vld = 1'b1; calc_en = 1'b1; byte_data = 8'hFF; ecc_clr = 1'b1;
    tick;
    byte_vld = 1'b0; calc_en = 1'b0; ecc_clr = 1'b0;
    model_zero;
    chk("R8 clear wins", lpr, 32'h0);
    put(8'h01, 1'b1);
    chk("R8 counter cleared", lpr, 32'h0000_5555);

    // R2: clear restarts readout position and byte counter
    clear;
    for (int i = 0; i < 240; i++) put(8'h00, 1'b1);
    put(8'h01, 1'b1);
    rd_one("R2 pre");
    rd_one("R2 pre");
    chk("R2 slot1", {24'h0, rd_byte}, 32'h0000_00AA);
    clear;
    chk("R2 rd_byte cleared", {24'h0, rd_byte}, 32'h0);
    for (int i = 0; i < 240; i++) put(8'h00, 1'b1);
    put(8'h01, 1'b1);
    rd_one("R2 pointer restart");
    chk("R2 slot0", {24'h0, rd_byte}, 32'h0000_0055);

    // R9: mid-run reset
    put(8'h5A, 1'b1);
    rst = 1'b1;
    tick;
    rst = 1'b0;
    model_zero;
    chk_par("R9 mid reset");
    chk("R9 mid reset", {24'h0, rd_byte}, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule